// File: doc/BRIEF.md
# Software Standby Entry and Wake Sequencer

This block decides when a small microcontroller may drop into its deep software standby state, switches the oscillator and the chip-wide clock gate off and back on, and reports which event woke the chip. The CPU raises a one-cycle sleep strobe. A standby-select bit picks either deep standby or ordinary sleep. Before the block accepts deep standby, it checks that the watchdog is not running in watchdog mode, that bus release is disabled and that the chosen settling delay is long enough for a crystal.

An interrupt wake (NMI, or an IRQ line that is both enabled and not masked) turns the oscillator on first. The clock gate stays closed for a settling window of 2^(BASE_LOG2 + settle select + divider select) raw clock cycles. The window length is captured when standby is entered. After the window the gate opens and a one-cycle interrupt-start pulse is issued. A low reset pin restores oscillator and clocks on the next cycle with no settling wait, and reports reset-start when the pin is released. A low hardware-standby pin forces the hardware standby state, with the oscillator and gate off, from any state. The only way out of hardware standby is the reset pin.

Top module: `stby_wake_ctrl`

## Requirements
- R1: With the block running, a sleep strobe with standby select at 1 and a legal setting puts it in standby on the next cycle: in_standby is 1 and osc_en and clk_gate_en are 0.
- R2: A sleep strobe with standby select at 0 gives a one-cycle sleep_req pulse on the next cycle. osc_en and clk_gate_en stay at 1 and standby is not entered.
- R3: An interrupt wake turns osc_en on at the next cycle. clk_gate_en then stays at 0 for exactly 2^(BASE_LOG2+sts_sel+div_sel) cycles, after which clk_gate_en returns to 1 together with a one-cycle irq_start pulse.
- R4: IRQ line k wakes the block only when irq_en[k] is 1 and irq_mask[k] is 0. Any other combination leaves it in standby.
- R5: A low res_pin_n in any state makes osc_en and clk_gate_en both 1 on the next cycle, with no settling wait. The cycle after the pin is seen high again carries a one-cycle reset_start pulse, and the block is then running.
- R6: A low hstby_pin_n while res_pin_n is high makes hw_stby_req 1 and osc_en and clk_gate_en 0 on the next cycle, from any state. Hardware standby is left only through a low res_pin_n.
- R7: A standby strobe while wdt_wd_mode or bus_rel_en is 1 is refused. refuse_err becomes 1 and the block keeps running. refuse_err returns to 0 at the next accepted standby entry.
- R8: With ext_clk_mode at 0, standby is refused as in R7 when BASE_LOG2+sts_sel+div_sel is below MIN_LOG2. With ext_clk_mode at 1, any setting is accepted.
- R9: The settling length is taken at standby entry. Changes to sts_sel or div_sel during standby do not alter it.
- R10: wake_cause is one-hot or zero, with bit 0 for reset, bit 1 for hardware standby, bit 2 for NMI and bit 3+k for IRQ k. When sources coincide the lowest bit wins. It is loaded on entry into reset hold, hardware standby or settling.
- R11: While por_n is low, osc_en and clk_gate_en are 1 and every other output is 0.
- R12: A sleep strobe outside the running state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| sleep_stb | input | 1 | One-cycle sleep strobe from the CPU |
| sby_sel | input | 1 | 1 selects software standby, 0 selects ordinary sleep |
| sts_sel | input | 3 | Settling-time select |
| div_sel | input | 2 | Clock-divider select, lengthens the settling window |
| ext_clk_mode | input | 1 | 1 when an external clock is used instead of a crystal |
| wdt_wd_mode | input | 1 | Watchdog is running in watchdog mode |
| bus_rel_en | input | 1 | Bus release is enabled |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | IRQ_N | External interrupt requests |
| irq_en | input | IRQ_N | Per-line interrupt enable |
| irq_mask | input | IRQ_N | Per-line CPU mask, 1 blocks the line |
| res_pin_n | input | 1 | Reset pin, active low |
| hstby_pin_n | input | 1 | Hardware standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Chip-wide clock gate enable |
| in_standby | output | 1 | Software standby is active |
| hw_stby_req | output | 1 | Request to the hardware standby logic |
| sleep_req | output | 1 | Ordinary sleep pulse |
| refuse_err | output | 1 | Last standby request was refused |
| wake_cause | output | IRQ_N+3 | One-hot wake source |
| irq_start | output | 1 | Pulse: begin interrupt handling |
| reset_start | output | 1 | Pulse: begin reset handling |

## Verification
The bench builds the block with BASE_LOG2 = 2, MIN_LOG2 = 6 and IRQ_N = 3. With these values settling windows run from 4 to 4096 cycles, so both the shortest window and a window whose select was rewritten to its maximum during standby can be timed cycle by cycle. The crystal-mode legality limit falls between a settle-plus-divider sum of 3 and one of 4, so both a refused setting and a just-legal setting are easy to reach. Three IRQ lines are enough to cover a disabled line, a masked line and the lowest-priority line winning on its own.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_STBY    = 3'd1,
      ST_SETTLE  = 3'd2,
      ST_RSTHOLD = 3'd3,
      ST_HWSTBY  = 3'd4
   } stby_state_e;

   // fixed wake-cause bit positions, IRQ lines follow from IDX_IRQ0 upward
   localparam int IDX_RES  = 0;
   localparam int IDX_HW   = 1;
   localparam int IDX_NMI  = 2;
   localparam int IDX_IRQ0 = 3;

   localparam int EXP_W = 8;

endpackage

// File: rtl/stby_entry_chk.sv
module stby_entry_chk
   import stby_wake_pkg::*;
#(
   parameter int BASE_LOG2 = 13,
   parameter int MIN_LOG2  = 17,
   parameter int CNT_W     = 24
) (
   input  logic [2:0]       sts_sel,
   input  logic [1:0]       div_sel,
   input  logic             ext_clk_mode,
   input  logic             wdt_wd_mode,
   input  logic             bus_rel_en,
   output logic             legal,
   output logic [CNT_W-1:0] len_m1
);

   logic [EXP_W-1:0] exp_v;
   logic             long_enough;

   always_comb begin
      exp_v       = EXP_W'(BASE_LOG2) + EXP_W'(sts_sel) + EXP_W'(div_sel);
      len_m1      = (CNT_W'(1) << exp_v) - CNT_W'(1);
      long_enough = ext_clk_mode || (exp_v >= EXP_W'(MIN_LOG2));
      legal       = !wdt_wd_mode && !bus_rel_en && long_enough;
   end

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/stby_wake_arb.sv
module stby_wake_arb #(
   parameter int IRQ_N = 3
) (
   input  logic             res_pin_n,
   input  logic             hstby_pin_n,
   input  logic             irq_window,
   input  logic             nmi,
   input  logic [IRQ_N-1:0] irq,
   input  logic [IRQ_N-1:0] irq_en,
   input  logic [IRQ_N-1:0] irq_mask,
   output logic [IRQ_N+2:0] grant,
   output logic             int_wake
);

   localparam int SRC_N = IRQ_N + 3;

   logic [SRC_N-1:0] req;
   logic [SRC_N:0]   taken;

   assign req[0] = !res_pin_n;
   assign req[1] = !hstby_pin_n;
   assign req[2] = irq_window & nmi;

   for (genvar k = 0; k < IRQ_N; k++) begin : g_irq_qual
      assign req[3+k] = irq_window & irq[k] & irq_en[k] & !irq_mask[k];
   end

   assign taken[0] = 1'b0;

   for (genvar i = 0; i < SRC_N; i++) begin : g_prio
      assign grant[i]   = req[i] & !taken[i];
      assign taken[i+1] = taken[i] | req[i];
   end

   assign int_wake = |req[SRC_N-1:2];

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
   import stby_wake_pkg::*;
#(
   parameter int BASE_LOG2 = 13,
   parameter int MIN_LOG2  = 17,
   parameter int IRQ_N     = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sleep_stb,
   input  logic             sby_sel,
   input  logic [2:0]       sts_sel,
   input  logic [1:0]       div_sel,
   input  logic             ext_clk_mode,
   input  logic             wdt_wd_mode,
   input  logic             bus_rel_en,
   input  logic             nmi,
   input  logic [IRQ_N-1:0] irq,
   input  logic [IRQ_N-1:0] irq_en,
   input  logic [IRQ_N-1:0] irq_mask,
   input  logic             res_pin_n,
   input  logic             hstby_pin_n,
   output logic             osc_en,
   output logic             clk_gate_en,
   output logic             in_standby,
   output logic             hw_stby_req,
   output logic             sleep_req,
   output logic             refuse_err,
   output logic [IRQ_N+2:0] wake_cause,
   output logic             irq_start,
   output logic             reset_start
);

   localparam int CNT_W = BASE_LOG2 + 11;
   localparam int SRC_N = IRQ_N + 3;

   // elaboration-time parameter checks
   if (BASE_LOG2 < 1 || BASE_LOG2 > 40) begin : g_bad_base
      $error("stby_wake_ctrl: BASE_LOG2 out of range");
   end
   if (IRQ_N < 1 || IRQ_N > 8) begin : g_bad_irq
      $error("stby_wake_ctrl: IRQ_N out of range");
   end
   if (MIN_LOG2 > BASE_LOG2 + 10) begin : g_bad_min
      $error("stby_wake_ctrl: MIN_LOG2 unreachable in crystal mode");
   end

   stby_state_e      state_q, state_d;
   logic             legal;
   logic [CNT_W-1:0] len_m1;
   logic             settle_done;
   logic [SRC_N-1:0] grant;
   logic             int_wake;
   logic             do_load, set_err, clr_err;
   logic             slp_d, irqs_d, rsts_d, cause_upd;

   stby_entry_chk #(
      .BASE_LOG2 (BASE_LOG2),
      .MIN_LOG2  (MIN_LOG2),
      .CNT_W     (CNT_W)
   ) u_entry (
      .sts_sel      (sts_sel),
      .div_sel      (div_sel),
      .ext_clk_mode (ext_clk_mode),
      .wdt_wd_mode  (wdt_wd_mode),
      .bus_rel_en   (bus_rel_en),
      .legal        (legal),
      .len_m1       (len_m1)
   );

   stby_settle_cnt #(
      .CNT_W (CNT_W)
   ) u_settle (
      .clk      (clk),
      .por_n    (por_n),
      .load     (do_load),
      .load_val (len_m1),
      .run      (state_q == ST_SETTLE),
      .done     (settle_done)
   );

   stby_wake_arb #(
      .IRQ_N (IRQ_N)
   ) u_arb (
      .res_pin_n   (res_pin_n),
      .hstby_pin_n (hstby_pin_n),
      .irq_window  (state_q == ST_STBY),
      .nmi         (nmi),
      .irq         (irq),
      .irq_en      (irq_en),
      .irq_mask    (irq_mask),
      .grant       (grant),
      .int_wake    (int_wake)
   );

   always_comb begin
      state_d = state_q;
      do_load = 1'b0;
      set_err = 1'b0;
      clr_err = 1'b0;
      slp_d   = 1'b0;
      irqs_d  = 1'b0;
      rsts_d  = 1'b0;
      if (grant[IDX_RES]) begin
         state_d = ST_RSTHOLD;
      end else if (grant[IDX_HW]) begin
         state_d = ST_HWSTBY;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (sleep_stb) begin
                  if (!sby_sel) begin
                     slp_d = 1'b1;
                  end else if (legal) begin
                     state_d = ST_STBY;
                     do_load = 1'b1;
                     clr_err = 1'b1;
                  end else begin
                     set_err = 1'b1;
                  end
               end
            end
            ST_STBY: begin
               if (int_wake) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_done) begin
                  state_d = ST_RUN;
                  irqs_d  = 1'b1;
               end
            end
            ST_RSTHOLD: begin
               state_d = ST_RUN;
               rsts_d  = 1'b1;
            end
            ST_HWSTBY: begin
               state_d = ST_HWSTBY;
            end
            default: begin
               state_d = ST_RUN;
            end
         endcase
      end
      cause_upd = (state_d != state_q) &&
                  (state_d inside {ST_RSTHOLD, ST_HWSTBY, ST_SETTLE});
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q     <= ST_RUN;
         refuse_err  <= 1'b0;
         wake_cause  <= '0;
         sleep_req   <= 1'b0;
         irq_start   <= 1'b0;
         reset_start <= 1'b0;
      end else begin
         state_q     <= state_d;
         sleep_req   <= slp_d;
         irq_start   <= irqs_d;
         reset_start <= rsts_d;
         if (set_err) begin
            refuse_err <= 1'b1;
         end else if (clr_err) begin
            refuse_err <= 1'b0;
         end
         if (cause_upd) begin
            wake_cause <= grant;
         end
      end
   end

   assign osc_en      = state_q inside {ST_RUN, ST_SETTLE, ST_RSTHOLD};
   assign clk_gate_en = state_q inside {ST_RUN, ST_RSTHOLD};
   assign in_standby  = (state_q == ST_STBY);
   assign hw_stby_req = (state_q == ST_HWSTBY);

endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk #(
   parameter int IRQ_N = 3
) (
   input logic             clk,
   input logic             por_n,
   input logic             res_pin_n,
   input logic             hstby_pin_n,
   input logic             osc_en,
   input logic             clk_gate_en,
   input logic             in_standby,
   input logic             hw_stby_req,
   input logic             sleep_req,
   input logic             refuse_err,
   input logic [IRQ_N+2:0] wake_cause,
   input logic             irq_start,
   input logic             reset_start
);

   AST_STBY_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!por_n)
      in_standby |-> (!osc_en && !clk_gate_en)); // R1

   AST_SLEEP_KEEPS_RUN: assert property (@(posedge clk) disable iff (!por_n)
      sleep_req |-> (clk_gate_en && !in_standby)); // R2

   AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
      clk_gate_en |-> osc_en); // R3

   AST_IRQ_START_PULSE: assert property (@(posedge clk) disable iff (!por_n)
      irq_start |=> !irq_start); // R3

   AST_IRQ_START_CLOCKED: assert property (@(posedge clk) disable iff (!por_n)
      irq_start |-> (clk_gate_en && osc_en)); // R3

   AST_RESET_FAST: assert property (@(posedge clk) disable iff (!por_n)
      !res_pin_n |=> (osc_en && clk_gate_en && !hw_stby_req)); // R5

   AST_RESET_START_AFTER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      reset_start |-> $past(clk_gate_en)); // R5

   AST_HW_STBY_FORCE: assert property (@(posedge clk) disable iff (!por_n)
      (res_pin_n && !hstby_pin_n) |=> (hw_stby_req && !osc_en && !clk_gate_en)); // R6

   AST_REFUSE_STAYS_RUN: assert property (@(posedge clk) disable iff (!por_n)
      $rose(refuse_err) |-> (!in_standby && clk_gate_en)); // R7

   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(wake_cause)); // R10

endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk #(.IRQ_N(IRQ_N)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .res_pin_n   (res_pin_n),
   .hstby_pin_n (hstby_pin_n),
   .osc_en      (osc_en),
   .clk_gate_en (clk_gate_en),
   .in_standby  (in_standby),
   .hw_stby_req (hw_stby_req),
   .sleep_req   (sleep_req),
   .refuse_err  (refuse_err),
   .wake_cause  (wake_cause),
   .irq_start   (irq_start),
   .reset_start (reset_start)
);

// File: tb/sim_stby_wake_ctrl.sv
`timescale 1ns/1ps
module sim_stby_wake_ctrl;

   localparam int BASE = 2;
   localparam int MINL = 6;
   localparam int NI   = 3;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sleep_stb = 0, sby_sel = 1, ext_clk_mode = 0, wdt_wd_mode = 0, bus_rel_en = 0;
   logic [2:0] sts_sel = 3'd3;
   logic [1:0] div_sel = 2'd1;
   logic nmi = 0;
   logic [NI-1:0] irq = '0, irq_en = '1, irq_mask = '0;
   logic res_pin_n = 1, hstby_pin_n = 1;
   logic osc_en, clk_gate_en, in_standby, hw_stby_req, sleep_req, refuse_err;
   logic irq_start, reset_start;
   logic [NI+2:0] wake_cause;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   stby_wake_ctrl #(.BASE_LOG2(BASE), .MIN_LOG2(MINL), .IRQ_N(NI)) u0 (
      .clk(clk), .por_n(por_n), .sleep_stb(sleep_stb), .sby_sel(sby_sel),
      .sts_sel(sts_sel), .div_sel(div_sel), .ext_clk_mode(ext_clk_mode),
      .wdt_wd_mode(wdt_wd_mode), .bus_rel_en(bus_rel_en), .nmi(nmi), .irq(irq),
      .irq_en(irq_en), .irq_mask(irq_mask), .res_pin_n(res_pin_n),
      .hstby_pin_n(hstby_pin_n), .osc_en(osc_en), .clk_gate_en(clk_gate_en),
      .in_standby(in_standby), .hw_stby_req(hw_stby_req), .sleep_req(sleep_req),
      .refuse_err(refuse_err), .wake_cause(wake_cause), .irq_start(irq_start),
      .reset_start(reset_start));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: phase 0 run, 1 standby, 2 settling, 3 reset hold, 4 hw standby
   int m_ph = 0;
   int m_rem = 0;
   logic [NI+2:0] m_cause = '0;
   logic m_err = 0, m_slp = 0, m_irqs = 0, m_rsts = 0;

   always @(posedge clk) begin
      if (!por_n) begin
         m_ph = 0; m_rem = 0; m_cause = '0;
         m_err = 0; m_slp = 0; m_irqs = 0; m_rsts = 0;
      end else begin
         int win;
         int e;
         m_slp = 0; m_irqs = 0; m_rsts = 0;
         win = -1;
         if (m_ph == 1) begin
            if (nmi) win = 2;
            else begin
               for (int k = 0; k < NI; k++)
                  if (win < 0 && irq[k] && irq_en[k] && !irq_mask[k]) win = 3 + k;
            end
         end
         if (!res_pin_n) begin
            if (m_ph != 3) m_cause = 1;
            m_ph = 3;
         end else if (!hstby_pin_n) begin
            if (m_ph != 4) m_cause = 2;
            m_ph = 4;
         end else if (m_ph == 0) begin
            if (sleep_stb) begin
               if (!sby_sel) m_slp = 1;
               else begin
                  e = BASE + int'(sts_sel) + int'(div_sel);
                  if (wdt_wd_mode || bus_rel_en || (!ext_clk_mode && e < MINL)) m_err = 1;
                  else begin m_err = 0; m_rem = 1 << e; m_ph = 1; end
               end
            end
         end else if (m_ph == 1) begin
            if (win >= 0) begin m_cause = '0; m_cause[win] = 1'b1; m_ph = 2; end
         end else if (m_ph == 2) begin
            m_rem--;
            if (m_rem == 0) begin m_ph = 0; m_irqs = 1; end
         end else if (m_ph == 3) begin
            m_ph = 0; m_rsts = 1;
         end
      end
   end

   // whole-output comparison every cycle, each output tied to its requirement
   always @(negedge clk) begin
      if (por_n) begin
         chk("R1 in_standby", 32'(in_standby), 32'(m_ph == 1));
         chk("R3 osc_en", 32'(osc_en), 32'(m_ph == 0 || m_ph == 2 || m_ph == 3));
         chk("R3 clk_gate_en", 32'(clk_gate_en), 32'(m_ph == 0 || m_ph == 3));
         chk("R3 irq_start", 32'(irq_start), 32'(m_irqs));
         chk("R2 sleep_req", 32'(sleep_req), 32'(m_slp));
         chk("R5 reset_start", 32'(reset_start), 32'(m_rsts));
         chk("R6 hw_stby_req", 32'(hw_stby_req), 32'(m_ph == 4));
         chk("R7 refuse_err", 32'(refuse_err), 32'(m_err));
         chk("R10 wake_cause", 32'(wake_cause), 32'(m_cause));
      end
   end

   task automatic tick(); @(negedge clk); endtask
   task automatic ticks(input int n); for (int i = 0; i < n; i++) @(negedge clk); endtask
   task automatic strobe(); sleep_stb = 1; tick(); sleep_stb = 0; endtask

   task automatic wait_settle(output int n);
      n = 0;
      while (!clk_gate_en && n < 10000) begin
         if (osc_en) n++;
         tick();
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int n;
      ticks(3);
      // R11 reset state
      chk("R11 osc_en", 32'(osc_en), 1);
      chk("R11 clk_gate_en", 32'(clk_gate_en), 1);
      chk("R11 others", {in_standby, hw_stby_req, sleep_req, refuse_err, irq_start, reset_start, wake_cause}, 0);
      por_n = 1;
      tick();

      // R2 ordinary sleep
      sby_sel = 0; strobe();
      chk("R2 sleep pulse", 32'(sleep_req), 1);
      chk("R2 clocks kept", {osc_en, clk_gate_en, in_standby}, 3'b110);
      tick();
      chk("R2 pulse width", 32'(sleep_req), 0);
      sby_sel = 1;

      // R7 refusals
      wdt_wd_mode = 1; strobe();
      chk("R7 watchdog refuse", {refuse_err, in_standby}, 2'b10);
      wdt_wd_mode = 0; bus_rel_en = 1; strobe();
      chk("R7 bus release refuse", {refuse_err, in_standby, clk_gate_en}, 3'b101);
      bus_rel_en = 0;

      // R8 crystal too short, then external clock accepted
      sts_sel = 0; div_sel = 0; strobe();
      chk("R8 crystal short refused", {refuse_err, in_standby}, 2'b10);
      ext_clk_mode = 1; strobe();
      chk("R8 external clock accepted", {refuse_err, in_standby}, 2'b01);
      chk("R1 clocks off", {osc_en, clk_gate_en}, 2'b00);
      nmi = 1; tick(); nmi = 0;
      chk("R3 oscillator first", {osc_en, clk_gate_en}, 2'b10);
      wait_settle(n);
      chk("R3 shortest window", 32'(n), 4);
      chk("R3 irq_start with gate", {irq_start, clk_gate_en}, 2'b11);
      chk("R10 nmi cause", 32'(wake_cause), 32'b000100);
      ext_clk_mode = 0;

      // R4 gated lines, R12 strobe in standby, R9 latched length
      sts_sel = 3; div_sel = 1; strobe();
      chk("R1 legal crystal entry", 32'(in_standby), 1);
      irq_en = 3'b110; irq = 3'b001; ticks(2); irq = '0;
      chk("R4 disabled irq0 ignored", {in_standby, osc_en}, 2'b10);
      irq_mask = 3'b010; irq = 3'b010; ticks(2); irq = '0;
      chk("R4 masked irq1 ignored", {in_standby, osc_en}, 2'b10);
      strobe();
      chk("R12 strobe ignored", {in_standby, sleep_req}, 2'b10);
      sts_sel = 7; div_sel = 3;
      irq = 3'b100; tick(); irq = '0;
      wait_settle(n);
      chk("R9 latched window", 32'(n), 64);
      chk("R10 irq2 cause", 32'(wake_cause), 32'b100000);
      irq_en = '1; irq_mask = '0; sts_sel = 3; div_sel = 1;

      // R10 nmi beats irq0
      strobe();
      nmi = 1; irq = 3'b001; tick(); nmi = 0; irq = '0;
      wait_settle(n);
      chk("R10 nmi over irq0", 32'(wake_cause), 32'b000100);
      chk("R3 window 64", 32'(n), 64);

      // R5 reset from standby
      strobe();
      res_pin_n = 0; tick();
      chk("R5 clocks at once", {osc_en, clk_gate_en}, 2'b11);
      chk("R10 reset cause", 32'(wake_cause), 32'b000001);
      ticks(2); res_pin_n = 1; tick();
      chk("R5 reset_start", 32'(reset_start), 1);
      tick();
      chk("R5 reset_start width", {reset_start, clk_gate_en}, 2'b01);

      // R5 reset during settling
      strobe();
      nmi = 1; tick(); nmi = 0; ticks(3);
      chk("R3 still settling", {osc_en, clk_gate_en}, 2'b10);
      res_pin_n = 0; tick();
      chk("R5 reset cuts settling", {osc_en, clk_gate_en}, 2'b11);
      res_pin_n = 1; ticks(2);

      // R6 hardware standby from running, exit only by reset
      hstby_pin_n = 0; tick();
      chk("R6 hw standby", {hw_stby_req, osc_en, clk_gate_en}, 3'b100);
      chk("R10 hw cause", 32'(wake_cause), 32'b000010);
      hstby_pin_n = 1; ticks(3);
      chk("R6 held without reset", 32'(hw_stby_req), 1);
      res_pin_n = 0; tick();
      chk("R6 reset exits", {hw_stby_req, clk_gate_en}, 2'b01);
      res_pin_n = 1; ticks(2);

      // R10 reset and hw standby together from standby
      strobe();
      res_pin_n = 0; hstby_pin_n = 0; tick();
      chk("R10 reset beats hw", 32'(wake_cause), 32'b000001);
      res_pin_n = 1; tick();
      chk("R6 hw after reset release", {hw_stby_req, reset_start}, 2'b10);
      hstby_pin_n = 1; res_pin_n = 0; tick(); res_pin_n = 1; ticks(2);

      // R6 hw standby from software standby
      strobe();
      hstby_pin_n = 0; tick();
      chk("R6 from standby", {hw_stby_req, in_standby}, 2'b10);
      hstby_pin_n = 1; res_pin_n = 0; tick(); res_pin_n = 1; ticks(2);
      chk("R5 running again", {clk_gate_en, in_standby}, 2'b10);

      finish_run();
   end

endmodule